// File: doc/BRIEF.md
# Dual-Clock Serial Field Delay Memory

This block is a first-in first-out field store whose write side and read side run on separate, unrelated clocks. Each side keeps its own address pointer, which normally steps by one location per enabled clock edge and wraps to zero after the last location. The distance between the two pointers sets the delay between a word going in and the same word coming out, so the block behaves like a long digital delay line.

Each side can be repositioned by holding its load input high and shifting a start address in one bit per clock on a single serial pin, least significant bit first. Each side has two kinds of enable. A stepping enable freezes the pointer when low. A data enable only masks the data: on the write side it protects the addressed location from being overwritten, and on the read side it blanks the output word, while the pointer keeps moving. Writes reach the storage array a fixed four write clocks after they are presented. A small synchronous array model, sized by a parameter, stands in for the storage.

Top module: `field_delay_mem`

## Requirements
- R1: After its reset each pointer is at location 0, and until the first enabled read `rdata` is all zeros and `rvalid` is low.
- R2: While a side's load input is high, each clock edge shifts that side's serial pin into a start-address register, least significant bit first, and the pointer neither steps nor transfers data. On the first edge with load low, the last AW bits shifted in become the current location.
- R3: A write edge with `wen` low stores nothing and leaves the write pointer unchanged.
- R4: A write edge with `wen` high and `wie` high stores the 24-bit `wdata` unchanged at the write pointer, and the pointer steps by one.
- R5: A write edge with `wen` high and `wie` low leaves the addressed location holding its old contents, while the write pointer still steps by one.
- R6: A write reaches the storage array on the fourth write-clock edge after the edge that captured it; a read of that location before then returns the old word.
- R7: A read edge with `ren` high and `rload` low loads the output from the read pointer's location and steps the pointer. With `ren` low, the pointer, `rdata` and `rvalid` all hold, whatever `roe` does.
- R8: A read edge with `ren` high and `roe` low still steps the read pointer, but drives `rdata` to all zeros with `rvalid` low. With `roe` high, `rvalid` goes high.
- R9: Both pointers return to location 0 after location DEPTH-1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk | input | 1 | Write-side clock |
| wrst_n | input | 1 | Write-side asynchronous reset, active low |
| wload | input | 1 | Write pointer load: shift start address while high |
| waddr_ser | input | 1 | Serial write start address, LSB first |
| wen | input | 1 | Write stepping enable |
| wie | input | 1 | Write data enable (storage mask) |
| wdata | input | DW | Input word |
| rclk | input | 1 | Read-side clock |
| rrst_n | input | 1 | Read-side asynchronous reset, active low |
| rload | input | 1 | Read pointer load: shift start address while high |
| raddr_ser | input | 1 | Serial read start address, LSB first |
| ren | input | 1 | Read stepping enable |
| roe | input | 1 | Read output enable (output mask) |
| rdata | output | DW | Output word, zero when masked |
| rvalid | output | 1 | Output word is unmasked |

## Verification
The embedded properties watch, on every edge, that each pointer holds, steps with wrap, or takes the shifted start address exactly as its enables and load input require. They also watch that a write leaves the pipeline four edges after capture with its address intact, and that a read output stays frozen on edges without a read. Whether masked writes really leave old contents in place, whether the serial address is assembled in the right bit order, and the exact crossing point where a pending write becomes visible to the read clock can only be shown by the bench's scenarios. These read the array back through the read port.

// File: rtl/fm_pkg.sv
package fm_pkg;

    // Write clocks between capture of a write and its arrival in storage.
    localparam int WR_LAT = 4;

    // Pointer side phase: normal running, or shifting in a start address.
    typedef enum logic {
        PH_RUN   = 1'b0,
        PH_SHIFT = 1'b1
    } port_phase_e;

endpackage

// File: rtl/fm_ptr.sv
module fm_ptr #(
    parameter int DEPTH = 64,
    parameter int AW    = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic          sbit,
    input  logic          adv,
    output logic [AW-1:0] cur
);
    import fm_pkg::*;

    localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

    typedef struct packed {
        port_phase_e   ph;
        logic [AW-1:0] sr;
        logic [AW-1:0] ptr;
    } pst_t;

    pst_t st_d, st_q;

    // Location in use on this edge: a freshly shifted start address wins.
    always_comb begin
        if (st_q.ph == PH_SHIFT && !load) begin
            cur = st_q.sr;
        end else begin
            cur = st_q.ptr;
        end
    end

    always_comb begin
        st_d = st_q;
        if (load) begin
            st_d.ph = PH_SHIFT;
            st_d.sr = {sbit, st_q.sr[AW-1:1]};
        end else begin
            st_d.ph = PH_RUN;
            if (adv) begin
                st_d.ptr = (cur == LAST) ? '0 : cur + AW'(1);
            end else begin
                st_d.ptr = cur;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{ph: PH_RUN, sr: '0, ptr: '0};
        end else begin
            st_q <= st_d;
        end
    end

    AST_PTR_SHIFT_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> $stable(st_q.ptr)) else $error("pointer moved while shifting"); // R2

    AST_PTR_TAKES_START: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.ph == PH_SHIFT && !load && !adv) |=> st_q.ptr == $past(st_q.sr))
        else $error("pointer did not take shifted start address"); // R2

    AST_PTR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.ph == PH_RUN && !load && !adv) |=> $stable(st_q.ptr))
        else $error("pointer moved without enable"); // R3

    AST_PTR_STEP_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.ph == PH_RUN && !load && adv) |=>
            st_q.ptr == (($past(st_q.ptr) == LAST) ? '0 : $past(st_q.ptr) + AW'(1)))
        else $error("pointer step or wrap wrong"); // R9

endmodule

// File: rtl/fm_wr_pipe.sv
module fm_wr_pipe #(
    parameter int AW = 6,
    parameter int DW = 24
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          in_v,
    input  logic [AW-1:0] in_addr,
    input  logic [DW-1:0] in_data,
    output logic          out_we,
    output logic [AW-1:0] out_addr,
    output logic [DW-1:0] out_data
);
    import fm_pkg::*;

    typedef struct packed {
        logic          v;
        logic [AW-1:0] a;
        logic [DW-1:0] d;
    } cmd_t;

    cmd_t [WR_LAT-1:0] stg_d, stg_q;

    always_comb begin
        stg_d[0].v = in_v;
        stg_d[0].a = in_addr;
        stg_d[0].d = in_data;
        for (int i = 1; i < WR_LAT; i++) begin
            stg_d[i] = stg_q[i-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stg_q <= '0;
        end else begin
            stg_q <= stg_d;
        end
    end

    assign out_we   = stg_q[WR_LAT-1].v;
    assign out_addr = stg_q[WR_LAT-1].a;
    assign out_data = stg_q[WR_LAT-1].d;

    // Cycles since reset, saturating, so $past never reaches into reset.
    logic [2:0] warm_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            warm_q <= '0;
        end else if (warm_q != 3'(WR_LAT)) begin
            warm_q <= warm_q + 3'd1;
        end
    end

    AST_WR_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        (warm_q == 3'(WR_LAT)) |-> out_we == $past(in_v, 4))
        else $error("write enable latency wrong"); // R6

    AST_WR_ADDR_CARRY: assert property (@(posedge clk) disable iff (!rst_n)
        (warm_q == 3'(WR_LAT) && out_we) |-> out_addr == $past(in_addr, 4))
        else $error("write address lost in pipeline"); // R6

endmodule

// File: rtl/fm_ram.sv
module fm_ram #(
    parameter int DEPTH = 64,
    parameter int AW    = $clog2(DEPTH),
    parameter int DW    = 24
) (
    input  logic          wclk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic          rclk,
    input  logic          re,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rword
);
    logic [DW-1:0] mem [DEPTH];

    always_ff @(posedge wclk) begin
        if (we) begin
            mem[waddr] <= wdata;
        end
    end

    always_ff @(posedge rclk) begin
        if (re) begin
            rword <= mem[raddr];
        end
    end

endmodule

// File: rtl/fm_rd_out.sv
module fm_rd_out #(
    parameter int DW = 24
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          step,
    input  logic          oe,
    input  logic [DW-1:0] word_i,
    output logic [DW-1:0] rdata,
    output logic          rvalid
);
    typedef struct packed {
        logic oe;
    } ost_t;

    ost_t os_d, os_q;

    always_comb begin
        os_d = os_q;
        if (step) begin
            os_d.oe = oe;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            os_q <= '0;
        end else begin
            os_q <= os_d;
        end
    end

    assign rvalid = os_q.oe;
    assign rdata  = os_q.oe ? word_i : '0;

    AST_RD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !step |=> $stable(rdata) && $stable(rvalid))
        else $error("output changed without read"); // R7

    AST_RD_MASK: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !oe) |=> (rdata == '0 && !rvalid))
        else $error("masked read not blanked"); // R8

endmodule

// File: rtl/field_delay_mem.sv
module field_delay_mem #(
    parameter int DEPTH = 64,
    parameter int DW    = 24
) (
    input  logic          wclk,
    input  logic          wrst_n,
    input  logic          wload,
    input  logic          waddr_ser,
    input  logic          wen,
    input  logic          wie,
    input  logic [DW-1:0] wdata,
    input  logic          rclk,
    input  logic          rrst_n,
    input  logic          rload,
    input  logic          raddr_ser,
    input  logic          ren,
    input  logic          roe,
    output logic [DW-1:0] rdata,
    output logic          rvalid
);
    localparam int AW = $clog2(DEPTH);

    logic [AW-1:0] wcur, rcur;
    logic          wstore, rstep;
    logic          ram_we;
    logic [AW-1:0] ram_waddr;
    logic [DW-1:0] ram_wdata, ram_rword;

    assign wstore = wen & wie & ~wload;
    assign rstep  = ren & ~rload;

    fm_ptr #(.DEPTH(DEPTH), .AW(AW)) u_wptr (
        .clk  (wclk),
        .rst_n(wrst_n),
        .load (wload),
        .sbit (waddr_ser),
        .adv  (wen),
        .cur  (wcur)
    );

    fm_wr_pipe #(.AW(AW), .DW(DW)) u_wpipe (
        .clk     (wclk),
        .rst_n   (wrst_n),
        .in_v    (wstore),
        .in_addr (wcur),
        .in_data (wdata),
        .out_we  (ram_we),
        .out_addr(ram_waddr),
        .out_data(ram_wdata)
    );

    fm_ptr #(.DEPTH(DEPTH), .AW(AW)) u_rptr (
        .clk  (rclk),
        .rst_n(rrst_n),
        .load (rload),
        .sbit (raddr_ser),
        .adv  (ren),
        .cur  (rcur)
    );

    fm_ram #(.DEPTH(DEPTH), .AW(AW), .DW(DW)) u_ram (
        .wclk (wclk),
        .we   (ram_we),
        .waddr(ram_waddr),
        .wdata(ram_wdata),
        .rclk (rclk),
        .re   (rstep),
        .raddr(rcur),
        .rword(ram_rword)
    );

    fm_rd_out #(.DW(DW)) u_rout (
        .clk   (rclk),
        .rst_n (rrst_n),
        .step  (rstep),
        .oe    (roe),
        .word_i(ram_rword),
        .rdata (rdata),
        .rvalid(rvalid)
    );

endmodule

// File: tb/tb_field_delay_mem.sv
module tb_field_delay_mem;
    localparam int DEPTH = 64;
    localparam int AW    = 6;
    localparam int DW    = 24;

    logic          wclk = 1'b0, rclk = 1'b0;
    logic          wrst_n = 1'b0, rrst_n = 1'b0;
    logic          wload = 1'b0, waddr_ser = 1'b0, wen = 1'b0, wie = 1'b0;
    logic [DW-1:0] wdata = '0;
    logic          rload = 1'b0, raddr_ser = 1'b0, ren = 1'b0, roe = 1'b0;
    logic [DW-1:0] rdata;
    logic          rvalid;

    field_delay_mem #(.DEPTH(DEPTH), .DW(DW)) dut (
        .wclk(wclk), .wrst_n(wrst_n), .wload(wload), .waddr_ser(waddr_ser),
        .wen(wen), .wie(wie), .wdata(wdata),
        .rclk(rclk), .rrst_n(rrst_n), .rload(rload), .raddr_ser(raddr_ser),
        .ren(ren), .roe(roe), .rdata(rdata), .rvalid(rvalid)
    );

    // 100 MHz on both sides; read edges trail write edges by 2 ns.
    always #5 wclk = ~wclk;
    initial begin
        #2;
        forever #5 rclk = ~rclk;
    end

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;
    logic [DW-1:0] exp_mem [DEPTH];
    logic [DW-1:0] got_d;
    logic          got_v;

    typedef struct packed {
        logic          we;
        logic          ie;
        logic [DW-1:0] d;
    } vec_t;

    localparam vec_t TBL [8] = '{
        '{1'b1, 1'b1, 24'h111111},
        '{1'b0, 1'b1, 24'h222222},
        '{1'b1, 1'b0, 24'h333333},
        '{1'b1, 1'b1, 24'h444444},
        '{1'b0, 1'b0, 24'h555555},
        '{1'b1, 1'b1, 24'hFFFFFF},
        '{1'b1, 1'b0, 24'h000000},
        '{1'b1, 1'b1, 24'h5A5A5A}
    };

    task automatic chk(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", tag, act, exp);
        end
    endtask

    task automatic report();
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    endtask

    task automatic w_cyc(input logic ld, input logic sb, input logic we,
                         input logic ie, input logic [DW-1:0] d);
        @(negedge wclk);
        wload = ld; waddr_ser = sb; wen = we; wie = ie; wdata = d;
        @(posedge wclk);
        #1;
        wload = 1'b0; wen = 1'b0; wie = 1'b0;
    endtask

    task automatic r_cyc(input logic ld, input logic sb, input logic re, input logic oe);
        @(negedge rclk);
        rload = ld; raddr_ser = sb; ren = re; roe = oe;
        @(posedge rclk);
        #2;
        got_d = rdata; got_v = rvalid;
        rload = 1'b0; ren = 1'b0;
    endtask

    task automatic wload_addr(input logic [AW-1:0] a);
        for (int i = 0; i < AW; i++) w_cyc(1'b1, a[i], 1'b0, 1'b0, '0);
    endtask

    task automatic rload_addr(input logic [AW-1:0] a);
        for (int i = 0; i < AW; i++) r_cyc(1'b1, a[i], 1'b0, 1'b0);
    endtask

    initial begin
        #100000;
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        report();
    end

    initial begin
        #33;
        wrst_n = 1'b1;
        rrst_n = 1'b1;
        #2;
        // R1: output blank after reset
        chk("R1 rdata", rdata, '0);
        chk("R1 rvalid", {23'd0, rvalid}, 24'd0);

        // R1 R4: fill from location 0 without any load; then wraps (R9)
        for (int i = 0; i < DEPTH; i++) begin
            w_cyc(1'b0, 1'b0, 1'b1, 1'b1, 24'hA00000 | DW'(i));
            exp_mem[i] = 24'hA00000 | DW'(i);
        end

        // Table walk from location 0 after write wrap: R3 R4 R5 R9
        begin
            int wp = 0;
            foreach (TBL[k]) begin
                w_cyc(1'b0, 1'b0, TBL[k].we, TBL[k].ie, TBL[k].d);
                if (TBL[k].we) begin
                    if (TBL[k].ie) exp_mem[wp] = TBL[k].d;
                    wp = (wp + 1) % DEPTH;
                end
            end
        end
        for (int i = 0; i < 4; i++) w_cyc(1'b0, 1'b0, 1'b0, 1'b0, '0);

        // Read everything back from 0 and past the end: R3 R4 R5 R9
        rload_addr('0);
        for (int i = 0; i < DEPTH + 2; i++) begin
            r_cyc(1'b0, 1'b0, 1'b1, 1'b1);
            if (i < 8) chk("R3 R4 R5 table readback", got_d, exp_mem[i]);
            else       chk("R9 read wrap", got_d, exp_mem[i % DEPTH]);
            chk("R8 valid with oe", {23'd0, got_v}, 24'd1);
        end

        // R8: masked read blanks output but pointer steps
        rload_addr(AW'(10));
        r_cyc(1'b0, 1'b0, 1'b1, 1'b0);
        chk("R8 masked data", got_d, '0);
        chk("R8 masked valid", {23'd0, got_v}, 24'd0);
        r_cyc(1'b0, 1'b0, 1'b1, 1'b1);
        chk("R8 pointer stepped", got_d, exp_mem[11]);

        // R7: no read enable holds pointer and output, oe ignored
        r_cyc(1'b0, 1'b0, 1'b0, 1'b1);
        r_cyc(1'b0, 1'b0, 1'b0, 1'b0);
        chk("R7 hold data", got_d, exp_mem[11]);
        chk("R7 hold valid", {23'd0, got_v}, 24'd1);
        r_cyc(1'b0, 1'b0, 1'b1, 1'b1);
        chk("R7 resume", got_d, exp_mem[12]);

        // R2: serial read start address 37 (LSB first)
        rload_addr(AW'(37));
        r_cyc(1'b0, 1'b0, 1'b1, 1'b1);
        chk("R2 read start", got_d, exp_mem[37]);

        // R2: serial write start address 45
        wload_addr(AW'(45));
        w_cyc(1'b0, 1'b0, 1'b1, 1'b1, 24'hC0FFEE);
        exp_mem[45] = 24'hC0FFEE;
        for (int i = 0; i < 4; i++) w_cyc(1'b0, 1'b0, 1'b0, 1'b0, '0);
        rload_addr(AW'(45));
        r_cyc(1'b0, 1'b0, 1'b1, 1'b1);
        chk("R2 write start", got_d, exp_mem[45]);
        r_cyc(1'b0, 1'b0, 1'b1, 1'b1);
        chk("R2 neighbour intact", got_d, exp_mem[46]);

        // R6: write to 20 is not visible before its fourth write edge
        rload_addr(AW'(20));
        wload_addr(AW'(20));
        w_cyc(1'b0, 1'b0, 1'b1, 1'b1, 24'h7E57ED);
        w_cyc(1'b0, 1'b0, 1'b0, 1'b0, '0);
        w_cyc(1'b0, 1'b0, 1'b0, 1'b0, '0);
        r_cyc(1'b0, 1'b0, 1'b1, 1'b1);
        chk("R6 old word before latency", got_d, exp_mem[20]);
        exp_mem[20] = 24'h7E57ED;
        w_cyc(1'b0, 1'b0, 1'b0, 1'b0, '0);
        w_cyc(1'b0, 1'b0, 1'b0, 1'b0, '0);
        rload_addr(AW'(20));
        r_cyc(1'b0, 1'b0, 1'b1, 1'b1);
        chk("R6 new word after latency", got_d, exp_mem[20]);

        report();
    end

endmodule